// File: doc/BRIEF.md
# Bus Monitor Message Capture Gate

This block decides when a serial avionics bus monitor begins and ends the capture of a message. It sits behind a Manchester word decoder and reads its per-word event strobes. These are a sync detection with its kind (command or data), a two-contiguous-bits indication, word completion with a parity verdict, and a word-invalid strobe. It also reads a single end-of-message-or-timeout strobe. From these it produces a capture-active level, a one-cycle strobe for each word that memory should keep, one-cycle open and close pulses around each message, and two status flags for the block status word: a sync error and an invalid word error.

Four start qualifications are selectable, from strictest to loosest. The strictest waits for a whole valid command word. The loosest accepts any sync followed by two good bits, so that word fragments and bad-parity words are caught while a failing bus is debugged. A separate control chooses whether a bad word inside a message ends the capture or is stored while capture goes on. The controller is a three-state machine: IDLE (waiting for a start), TRIG (capture opened early on two bits, triggering word still in flight) and RECORD (capture open). Its transitions are:

- START_WORD: IDLE to RECORD on a qualifying whole word.
- START_BITS: IDLE to TRIG on a qualifying sync plus two bits.
- TRIG_OK: TRIG to RECORD when the triggering word completes valid.
- TRIG_BAD_KEEP: TRIG to RECORD when the triggering word is bad and bad words are kept.
- TRIG_BAD_STOP: TRIG to IDLE when the triggering word is bad and bad words are not kept.
- REC_BAD_STOP: RECORD to IDLE on a bad word when bad words are not kept.
- END: TRIG or RECORD to IDLE on the end strobe.

Top module: `bm_rec_start`

## Requirements
- R1: After synchronous reset, rec_active, store_strobe, msg_start, msg_close, sync_err and invalid_err are all 0.
- R2: With cfg_start_mode = 2'b00, capture opens only when a word whose sync was a command sync (sync_is_cmd = 1 at sync_det) completes with word_done = 1 and parity_ok = 1. That word is stored. Data-sync words, bad-parity words (word_done = 1, parity_ok = 0) and word_bad words open nothing.
- R3: With cfg_start_mode = 2'b01, capture opens when a word of either sync kind completes with word_done = 1 and parity_ok = 1. That word is stored.
- R4: With cfg_start_mode = 2'b10, capture opens on bits_ok following a command sync, whatever the word's later outcome. Data syncs open nothing.
- R5: With cfg_start_mode = 2'b11, capture opens on bits_ok following a sync of either kind.
- R6: sync_err is 1 for a message opened on a data sync (sync_is_cmd = 0), and 0 for one opened on a command sync.
- R7: In modes 2'b10 and 2'b11 the triggering word is always stored. If it ends bad (word_bad = 1, or word_done = 1 with parity_ok = 0), invalid_err is set. A bad word later in the message does not set invalid_err.
- R8: With cfg_keep_invalid = 0, a bad word while capture is open is not stored (except the mode 2'b10/2'b11 triggering word), and the message closes: msg_close pulses and rec_active drops.
- R9: With cfg_keep_invalid = 1, a bad word while capture is open is stored and capture stays open until msg_end.
- R10: Configuration inputs act only through the values held while IDLE. Changing cfg_keep_invalid or cfg_start_mode during an open message does not alter that message; the new values govern the next one.
- R11: Each event is answered on the clock edge that samples it. store_strobe is a one-cycle pulse per stored word, and msg_start and msg_close are one-cycle pulses. The flags are loaded at msg_start, held through the msg_close cycle and read 0 on the cycle after it.
- R12: msg_end while IDLE has no effect: no msg_close pulse and capture stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_start_mode | input | 2 | Start qualification: 00 valid command word, 01 valid word of any sync, 10 command sync + two bits, 11 any sync + two bits |
| cfg_keep_invalid | input | 1 | 1: store bad words and keep capturing; 0: drop the bad word and close |
| sync_det | input | 1 | Decoder found a sync (one-cycle strobe) |
| sync_is_cmd | input | 1 | Sync kind qualifying sync_det: 1 command, 0 data |
| bits_ok | input | 1 | Two contiguous valid bits followed the sync (strobe) |
| word_done | input | 1 | Word fully received (strobe) |
| parity_ok | input | 1 | Odd parity correct, qualifies word_done |
| word_bad | input | 1 | Word encoding failed (strobe) |
| msg_end | input | 1 | End of message or timeout (strobe) |
| rec_active | output | 1 | Capture is open |
| store_strobe | output | 1 | Store the word just received (one cycle) |
| msg_start | output | 1 | Message capture opened (one cycle) |
| msg_close | output | 1 | Message capture closed (one cycle) |
| sync_err | output | 1 | Status: message opened on a data sync |
| invalid_err | output | 1 | Status: triggering word in a two-bit mode ended bad |

## Verification
The main function is swept over every start mode, both sync kinds, both settings of the bad-word control and three outcomes for the first word: valid, bad parity and encoding failure. This separates the whole-word modes from the two-bit modes, since only the latter open on a failed word. It also separates the command-only modes from the any-sync modes through the data-sync cases. A valid command word follows each first word, so the bench sees whether the first word left capture open (the follow-up is stored in place) or closed (it opens a fresh message with cleared flags). Directed sequences cover bad words in mid-message under both control settings, configuration changes during an open message, and an end strobe while idle.

// File: rtl/bm_rec_pkg.sv
package bm_rec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRIG   = 2'd1,
        ST_RECORD = 2'd2
    } rec_state_t;

    typedef enum logic [1:0] {
        MODE_CMD_WORD = 2'b00,
        MODE_ANY_WORD = 2'b01,
        MODE_CMD_BITS = 2'b10,
        MODE_ANY_BITS = 2'b11
    } start_mode_t;

endpackage

// File: rtl/bm_start_qual.sv
module bm_start_qual
    import bm_rec_pkg::*;
(
    input  start_mode_t mode,
    input  logic        sync_seen,
    input  logic        sync_cmd,
    input  logic        bits_ok,
    input  logic        word_ok,
    output logic        start_now,
    output logic        start_early,
    output logic        start_data
);

    logic kind_ok;

    always_comb begin
        kind_ok     = 1'b0;
        start_now   = 1'b0;
        start_early = 1'b0;
        unique case (mode)
            MODE_CMD_WORD: begin
                kind_ok   = sync_cmd;
                start_now = sync_seen && kind_ok && word_ok;
            end
            MODE_ANY_WORD: begin
                kind_ok   = 1'b1;
                start_now = sync_seen && word_ok;
            end
            MODE_CMD_BITS: begin
                kind_ok     = sync_cmd;
                start_now   = sync_seen && kind_ok && bits_ok;
                start_early = start_now;
            end
            MODE_ANY_BITS: begin
                kind_ok     = 1'b1;
                start_now   = sync_seen && bits_ok;
                start_early = start_now;
            end
            default: begin
                kind_ok   = 1'b0;
                start_now = 1'b0;
            end
        endcase
        start_data = start_now && kind_ok && !sync_cmd;
    end

endmodule

// File: rtl/bm_status_flags.sv
module bm_status_flags (
    input  logic clk,
    input  logic rst,
    input  logic open_msg,
    input  logic open_on_data,
    input  logic mark_invalid,
    input  logic clear_req,
    output logic sync_err,
    output logic invalid_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_err    <= 1'b0;
            invalid_err <= 1'b0;
        end else if (open_msg) begin
            sync_err    <= open_on_data;
            invalid_err <= 1'b0;
        end else begin
            if (clear_req) begin
                sync_err    <= 1'b0;
                invalid_err <= 1'b0;
            end
            if (mark_invalid) begin
                invalid_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bm_rec_start.sv
module bm_rec_start
    import bm_rec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_start_mode,
    input  logic       cfg_keep_invalid,
    input  logic       sync_det,
    input  logic       sync_is_cmd,
    input  logic       bits_ok,
    input  logic       word_done,
    input  logic       parity_ok,
    input  logic       word_bad,
    input  logic       msg_end,
    output logic       rec_active,
    output logic       store_strobe,
    output logic       msg_start,
    output logic       msg_close,
    output logic       sync_err,
    output logic       invalid_err
);

    rec_state_t state_q, state_d;
    logic       sync_seen_q, sync_cmd_q;
    logic       keep_q;
    logic       word_ok, word_inv;
    logic       start_now, start_early, start_data;
    logic       do_start, do_store, do_close, do_mark;

    assign word_ok  = word_done && parity_ok;
    assign word_inv = word_bad || (word_done && !parity_ok);

    // Track the sync of the word currently in flight.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_seen_q <= 1'b0;
            sync_cmd_q  <= 1'b0;
        end else if (sync_det) begin
            sync_seen_q <= 1'b1;
            sync_cmd_q  <= sync_is_cmd;
        end else if (word_done || word_bad) begin
            sync_seen_q <= 1'b0;
        end
    end

    // Bad-word policy is frozen once a message is open.
    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            keep_q <= cfg_keep_invalid;
        end
    end

    bm_start_qual u_qual (
        .mode        (start_mode_t'(cfg_start_mode)),
        .sync_seen   (sync_seen_q),
        .sync_cmd    (sync_cmd_q),
        .bits_ok     (bits_ok),
        .word_ok     (word_ok),
        .start_now   (start_now),
        .start_early (start_early),
        .start_data  (start_data)
    );

    // Next state and event decode.
    always_comb begin
        state_d  = state_q;
        do_start = 1'b0;
        do_store = 1'b0;
        do_close = 1'b0;
        do_mark  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_now) begin
                    do_start = 1'b1;
                    if (start_early) begin
                        state_d = ST_TRIG;
                    end else begin
                        state_d  = ST_RECORD;
                        do_store = 1'b1;
                    end
                end
            end
            ST_TRIG: begin
                if (word_ok) begin
                    do_store = 1'b1;
                    state_d  = ST_RECORD;
                end else if (word_inv) begin
                    do_store = 1'b1;
                    do_mark  = 1'b1;
                    if (keep_q) begin
                        state_d = ST_RECORD;
                    end else begin
                        do_close = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
                if (msg_end) begin
                    do_close = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_RECORD: begin
                if (word_ok) begin
                    do_store = 1'b1;
                end else if (word_inv) begin
                    if (keep_q) begin
                        do_store = 1'b1;
                    end else begin
                        do_close = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
                if (msg_end) begin
                    do_close = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output strobes.
    always_ff @(posedge clk) begin
        if (rst) begin
            store_strobe <= 1'b0;
            msg_start    <= 1'b0;
            msg_close    <= 1'b0;
        end else begin
            store_strobe <= do_store;
            msg_start    <= do_start;
            msg_close    <= do_close;
        end
    end

    assign rec_active = (state_q != ST_IDLE);

    bm_status_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .open_msg     (do_start),
        .open_on_data (start_data),
        .mark_invalid (do_mark),
        .clear_req    (msg_close),
        .sync_err     (sync_err),
        .invalid_err  (invalid_err)
    );

endmodule

// File: rtl/bm_rec_start_chk.sv
module bm_rec_start_chk (
    input logic clk,
    input logic rst,
    input logic rec_active,
    input logic store_strobe,
    input logic msg_start,
    input logic msg_close,
    input logic sync_err,
    input logic invalid_err
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rec_active && !sync_err && !invalid_err));

    a_r11_open_close_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({msg_start, msg_close}));

    a_r11_open_means_active: assert property (@(posedge clk) disable iff (rst)
        msg_start |-> rec_active);

    a_r8_close_means_idle: assert property (@(posedge clk) disable iff (rst)
        msg_close |-> !rec_active);

    a_r11_store_inside_message: assert property (@(posedge clk) disable iff (rst)
        store_strobe |-> (rec_active || msg_close));

    a_r6_sync_err_only_at_open: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> msg_start);

    a_r7_invalid_with_store: assert property (@(posedge clk) disable iff (rst)
        $rose(invalid_err) |-> store_strobe);

    a_r11_flags_clear_after_close: assert property (@(posedge clk) disable iff (rst)
        msg_close |=> (!invalid_err && (msg_start || !sync_err)));

    a_r12_no_close_from_idle: assert property (@(posedge clk) disable iff (rst)
        !rec_active |=> !msg_close);

endmodule

bind bm_rec_start bm_rec_start_chk u_chk (.*);

// File: tb/bm_rec_start_bench.sv
`timescale 1ns/1ps
module bm_rec_start_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_start_mode = 2'b00;
    logic       cfg_keep_invalid = 1'b0;
    logic       sync_det = 1'b0, sync_is_cmd = 1'b0, bits_ok = 1'b0;
    logic       word_done = 1'b0, parity_ok = 1'b0, word_bad = 1'b0, msg_end = 1'b0;
    logic       rec_active, store_strobe, msg_start, msg_close, sync_err, invalid_err;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0, n_store = 0, n_close = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bm_rec_start u_bm_rec_start (
        .clk (clk), .rst (rst),
        .cfg_start_mode (cfg_start_mode), .cfg_keep_invalid (cfg_keep_invalid),
        .sync_det (sync_det), .sync_is_cmd (sync_is_cmd), .bits_ok (bits_ok),
        .word_done (word_done), .parity_ok (parity_ok), .word_bad (word_bad),
        .msg_end (msg_end),
        .rec_active (rec_active), .store_strobe (store_strobe),
        .msg_start (msg_start), .msg_close (msg_close),
        .sync_err (sync_err), .invalid_err (invalid_err)
    );

    always @(negedge clk) begin
        if (rst) begin
            n_start = 0; n_store = 0; n_close = 0;
        end else begin
            n_start += int'(msg_start);
            n_store += int'(store_strobe);
            n_close += int'(msg_close);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // kind: 0 valid, 1 bad parity, 2 encoding failure
    task automatic send_word(input bit cmd, input int kind);
        @(negedge clk) begin sync_det = 1'b1; sync_is_cmd = cmd; end
        @(negedge clk) sync_det = 1'b0;
        @(negedge clk) bits_ok = 1'b1;
        @(negedge clk) bits_ok = 1'b0;
        @(negedge clk) begin
            if (kind == 2) word_bad = 1'b1;
            else begin word_done = 1'b1; parity_ok = (kind == 0); end
        end
        @(negedge clk) begin word_bad = 1'b0; word_done = 1'b0; parity_ok = 1'b0; end
        #1;
    endtask

    task automatic end_msg();
        @(negedge clk) msg_end = 1'b1;
        @(negedge clk) msg_end = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        #1;
        chk("R1", "rec_active", int'(rec_active), 0);
        chk("R1", "strobes", int'(store_strobe) + int'(msg_start) + int'(msg_close), 0);
        chk("R1", "flags", int'(sync_err) + int'(invalid_err), 0);

        // Sweep: mode x sync kind x keep x first-word outcome
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int kind = 0; kind < 3; kind++) begin
                        string rt;
                        bit two_bit, sync_ok, st1, inv_trig, cl1, rec1;
                        rt = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
                        two_bit  = (m >= 2);
                        sync_ok  = (c == 1) || (m % 2 == 1);
                        st1      = sync_ok && (two_bit || kind == 0);
                        inv_trig = two_bit && (kind != 0);
                        cl1      = st1 && inv_trig && (k == 0);
                        rec1     = st1 && !cl1;
                        cfg_start_mode   = 2'(m);
                        cfg_keep_invalid = k[0];
                        do_reset();
                        send_word(c[0], kind);
                        chk(rt, "opens after first word", n_start, int'(st1));
                        chk("R7", "stores after first word", n_store, int'(st1));
                        chk("R8", "closes after first word", n_close, int'(cl1));
                        chk(rt, "rec_active after first word", int'(rec_active), int'(rec1));
                        chk("R6", "sync_err", int'(sync_err), int'(st1 && c == 0));
                        chk("R7", "invalid_err", int'(invalid_err), int'(st1 && inv_trig));
                        send_word(1'b1, 0);
                        chk("R11", "stores after follow-up", n_store, int'(st1) + 1);
                        chk("R11", "opens after follow-up", n_start, int'(st1) + (rec1 ? 0 : 1));
                        chk("R6", "sync_err after follow-up", int'(sync_err), int'(rec1 && c == 0));
                        chk("R7", "invalid_err after follow-up", int'(invalid_err), int'(rec1 && inv_trig));
                        end_msg();
                        chk("R11", "closes after end", n_close, int'(cl1) + 1);
                        chk("R11", "idle after end", int'(rec_active), 0);
                        @(negedge clk) #1;
                        chk("R11", "flags cleared after close", int'(sync_err) + int'(invalid_err), 0);
                    end
                end
            end
        end

        // R12: end strobe while idle
        cfg_start_mode = 2'b00; cfg_keep_invalid = 1'b0;
        do_reset();
        end_msg();
        @(negedge clk) #1;
        chk("R12", "no close when idle", n_close, 0);
        chk("R12", "stays idle", int'(rec_active), 0);

        // R9: bad mid-message words kept under keep=1, no invalid_err
        for (int kind = 1; kind < 3; kind++) begin
            cfg_start_mode = 2'b00; cfg_keep_invalid = 1'b1;
            do_reset();
            send_word(1'b1, 0);
            send_word(1'b0, kind);
            chk("R9", "bad word stored", n_store, 2);
            chk("R9", "still recording", int'(rec_active), 1);
            chk("R9", "no close", n_close, 0);
            chk("R7", "mid-message bad word leaves invalid_err", int'(invalid_err), 0);
            end_msg();
            chk("R9", "closed by end", n_close, 1);
        end

        // R8: bad mid-message words drop the message under keep=0
        for (int kind = 1; kind < 3; kind++) begin
            cfg_start_mode = 2'b01; cfg_keep_invalid = 1'b0;
            do_reset();
            send_word(1'b1, 0);
            send_word(1'b1, kind);
            chk("R8", "bad word not stored", n_store, 1);
            chk("R8", "message closed", n_close, 1);
            chk("R8", "recording stopped", int'(rec_active), 0);
        end

        // R10: configuration changes during an open message
        cfg_start_mode = 2'b00; cfg_keep_invalid = 1'b0;
        do_reset();
        send_word(1'b1, 0);
        cfg_keep_invalid = 1'b1;
        cfg_start_mode   = 2'b11;
        send_word(1'b1, 2);
        chk("R10", "old policy drops bad word", n_store, 1);
        chk("R10", "old policy closes", n_close, 1);
        send_word(1'b0, 2);
        chk("R10", "new mode opens on data sync bits", n_start, 2);
        chk("R10", "new policy keeps capture open", int'(rec_active), 1);
        chk("R6", "data sync open sets sync_err", int'(sync_err), 1);
        chk("R7", "failed trigger sets invalid_err", int'(invalid_err), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule